// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block takes the four level-sensitive PCI interrupt pins (A through D) and steers each one onto one of sixteen ISA interrupt request lines. Each pin has its own 4-bit routing field, which holds the target line number. An ISA line is high when at least one asserted pin has a field that points at it. When two or more pins share a line, their levels are ORed together.

The routing fields sit in three byte-wide registers. Software reaches them through a small register port with an address, a write strobe, write data and combinational read data. The fields are not packed evenly. Pin A uses the upper nibble of the first byte. Pins B and C share the second byte, B in the lower nibble and C in the upper nibble. Pin D uses the upper nibble of the third byte. The two remaining nibbles hold whatever is written to them but do not steer anything. The ISA outputs come from a register stage, so they follow the pins and the register contents with one clock of delay.

Top module: `pirq_router`

## Requirements
- R1: After a synchronous active-low reset, all three routing bytes read 0x00 and every ISA output is low.
- R2: A write to address 0x55, 0x56 or 0x57 stores the byte. A later read of that address returns the last byte written there.
- R3: A write to any other address leaves all three routing bytes unchanged. A read of any other address returns 0x00.
- R4: Pin A (input bit 0) is routed to the ISA line whose number is in bits [7:4] of byte 0x55.
- R5: Pin B (input bit 1) is routed to the ISA line whose number is in bits [3:0] of byte 0x56.
- R6: Pin C (input bit 2) is routed to the ISA line whose number is in bits [7:4] of byte 0x56.
- R7: Pin D (input bit 3) is routed to the ISA line whose number is in bits [7:4] of byte 0x57.
- R8: When several pins select the same ISA line, that line is high while any of them is high. It goes low only when all of them are low.
- R9: An ISA line that no asserted pin selects is low. All sixteen field values, 0 to 15, are valid targets.
- R10: Bits [3:0] of byte 0x55 and bits [3:0] of byte 0x57 can be read and written, but they have no effect on any ISA output.
- R11: The ISA outputs are registered. A pin change is visible on them after the next clock edge. A routing write that lands on edge k first shows up at edge k+1.
- R12: The routing can be changed while pins are asserted. The outputs then move to the newly selected lines and leave the old ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | 4 | PCI interrupt pin levels, bit 0 = pin A, bit 3 = pin D, high = asserted |
| reg_addr | input | 8 | Register port address |
| reg_we | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_out | output | 16 | ISA interrupt request levels, bit n = line n |

## Verification
The bench programs each field with distinct values, including the extreme targets 0 and 15. A design that took a field from the wrong nibble or the wrong byte would then light the wrong line. It routes pins to a shared line and drops them one at a time. A router that passes only the last pin it evaluated would clear the line too early. It writes unique values into the two storage-only nibbles. A decoder that read pin B's position for pin A or pin D would then show a stray line. It also remaps a line while its pin is held high, and it probes addresses next to the window, to catch an output that misses the one-cycle delay or an address decode that is off by one.

// File: rtl/pirq_pkg.sv
// Package: shared constants, types and field placement for the interrupt pin router.
// Assumes four pins, sixteen ISA lines, and nibble-wide routing fields.
package pirq_pkg;
    localparam int NUM_PINS  = 4;
    localparam int NUM_LINES = 16;
    localparam int SEL_W     = $clog2(NUM_LINES);
    localparam int NUM_REGS  = 3;
    localparam int BYTE_W    = 2 * SEL_W;

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Which routing byte holds the field for a given pin (0 = base address).
    function automatic int field_byte(input int pin);
        case (pin)
            0:       return 0;
            1:       return 1;
            2:       return 1;
            default: return 2;
        endcase
    endfunction

    // Whether the field sits in the upper nibble of its byte.
    function automatic bit field_upper(input int pin);
        return (pin != 1);
    endfunction
endpackage

// File: rtl/pirq_regfile.sv
// Module: three byte-wide routing registers behind an address/strobe port.
// Assumes a contiguous window of NUM_REGS bytes starting at BASE_ADDR;
// addresses outside the window read as zero and are not written.
module pirq_regfile
    import pirq_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h55
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_we,
    input  byte_t                      reg_wdata,
    output byte_t                      reg_rdata,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] regs
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [ADDR_W-1:0] offset;
    logic              in_window;
    logic [IDX_W-1:0]  idx;

    // Decode the address into a window hit and a byte index.
    always_comb begin
        offset    = reg_addr - BASE_ADDR;
        in_window = (reg_addr >= BASE_ADDR) && (offset < ADDR_W'(NUM_REGS));
        idx       = offset[IDX_W-1:0];
    end

    // Store each routing byte on a write that hits it.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[r] <= '0;
            else if (reg_we && in_window && (idx == IDX_W'(r)))
                regs[r] <= reg_wdata;
        end

        p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == BASE_ADDR + ADDR_W'(r)) |=> (regs[r] == $past(reg_wdata)))
            else $error("routing byte %0d did not take written data", r);

        p_hold_unwritten_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_we && reg_addr == BASE_ADDR + ADDR_W'(r)) |=> $stable(regs[r]))
            else $error("routing byte %0d changed without a write", r);
    end

    // Return the addressed byte, or zero outside the window.
    always_comb begin
        reg_rdata = '0;
        if (in_window)
            reg_rdata = regs[idx];
    end
endmodule

// File: rtl/pirq_field_map.sv
// Module: pulls each pin's 4-bit routing field out of the unevenly packed bytes.
// Assumes the placement given by field_byte/field_upper in the package;
// nibbles not named there are storage only.
module pirq_field_map
    import pirq_pkg::*;
(
    input  logic [NUM_REGS-1:0][BYTE_W-1:0] regs,
    output logic [NUM_PINS-1:0][SEL_W-1:0]  sel
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int  BI = field_byte(p);
        localparam bit  UP = field_upper(p);
        if (UP) begin : g_hi
            // Field in the upper nibble.
            assign sel[p] = regs[BI][BYTE_W-1:SEL_W];
        end else begin : g_lo
            // Field in the lower nibble.
            assign sel[p] = regs[BI][SEL_W-1:0];
        end
    end

    // Storage-only nibbles are consumed here on purpose.
    logic unused_nibbles;
    assign unused_nibbles = ^{regs[0][SEL_W-1:0], regs[2][SEL_W-1:0]};
endmodule

// File: rtl/pirq_or_matrix.sv
// Module: ORs every asserted pin onto the line its field selects, then registers it.
// Assumes every field value is a legal line number (SEL_W covers NUM_LINES).
module pirq_or_matrix
    import pirq_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0]            pin_lvl,
    input  logic [NUM_PINS-1:0][SEL_W-1:0] sel,
    output logic [NUM_LINES-1:0]           irq_q
);
    logic [NUM_LINES-1:0] hit;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        // A line is hit when any asserted pin selects it.
        always_comb begin
            hit[l] = 1'b0;
            for (int p = 0; p < NUM_PINS; p++)
                if (pin_lvl[p] && (sel[p] == SEL_W'(l)))
                    hit[l] = 1'b1;
        end
    end

    // Register the combined line levels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= '0;
        else
            irq_q <= hit;
    end

    p_quiet_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_lvl == '0) |=> (irq_q == '0))
        else $error("ISA line high with no pin asserted");

    p_lines_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(irq_q) <= $countones($past(pin_lvl))))
        else $error("more ISA lines high than pins asserted one cycle earlier");

    p_any_pin_lights_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_lvl != '0) |=> (irq_q != '0))
        else $error("asserted pin reached no ISA line");
endmodule

// File: rtl/pirq_router.sv
// Module: top of the PCI interrupt pin router.
// Assumes synchronous active-low reset; outputs trail inputs by one clock.
module pirq_router
    import pirq_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h55
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pin_lvl,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
    logic [NUM_PINS-1:0][SEL_W-1:0]  sel;

    pirq_regfile #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .regs      (regs)
    );

    pirq_field_map u_map (
        .regs (regs),
        .sel  (sel)
    );

    pirq_or_matrix u_or (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_lvl (pin_lvl),
        .sel     (sel),
        .irq_q   (irq_out)
    );

    p_outside_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < BASE_ADDR || reg_addr > BASE_ADDR + ADDR_W'(NUM_REGS - 1)) |-> (reg_rdata == '0))
        else $error("read outside the routing window returned data");
endmodule

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_lvl = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] shadow [3];

    always #5 clk = ~clk;

    pirq_router dut (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%h expected 0x%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        if (a >= 8'h55 && a <= 8'h57) shadow[a - 8'h55] = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    // Expected line levels from the field placement in the requirements.
    function automatic logic [15:0] model(input logic [3:0] p);
        logic [15:0] m = '0;
        if (p[0]) m[shadow[0][7:4]] = 1'b1;
        if (p[1]) m[shadow[1][3:0]] = 1'b1;
        if (p[2]) m[shadow[1][7:4]] = 1'b1;
        if (p[3]) m[shadow[2][7:4]] = 1'b1;
        return m;
    endfunction

    task automatic t_reset();
        rd_chk("R1", 8'h55, 8'h00);
        rd_chk("R1", 8'h56, 8'h00);
        rd_chk("R1", 8'h57, 8'h00);
        chk("R1", irq_out, 16'h0000);
    endtask

    task automatic t_rw();
        wr(8'h55, 8'hA3); wr(8'h56, 8'h5C); wr(8'h57, 8'h7E);
        rd_chk("R2", 8'h55, 8'hA3);
        rd_chk("R2", 8'h56, 8'h5C);
        rd_chk("R2", 8'h57, 8'h7E);
        wr(8'h56, 8'h12);
        rd_chk("R2", 8'h56, 8'h12);
    endtask

    task automatic t_outside();
        wr(8'h54, 8'hFF); wr(8'h58, 8'hFF); wr(8'h00, 8'hFF); wr(8'hD5, 8'hFF);
        rd_chk("R3", 8'h54, 8'h00);
        rd_chk("R3", 8'h58, 8'h00);
        rd_chk("R3", 8'hFF, 8'h00);
        rd_chk("R3", 8'h55, shadow[0]);
        rd_chk("R3", 8'h56, shadow[1]);
        rd_chk("R3", 8'h57, shadow[2]);
    endtask

    task automatic t_single(input string req, input int pin, input logic [3:0] line);
        pin_lvl = '0;
        case (pin)
            0: wr(8'h55, {line, 4'h0});
            1: wr(8'h56, {4'h0, line});
            2: wr(8'h56, {line, 4'h0});
            default: wr(8'h57, {line, 4'h0});
        endcase
        pin_lvl = 4'(1 << pin);
        step();
        chk(req, irq_out, 16'(1) << line);
        pin_lvl = '0;
        step();
        chk(req, irq_out, 16'h0000);
    endtask

    task automatic t_share();
        wr(8'h55, 8'h90); wr(8'h56, 8'h99); wr(8'h57, 8'h20);
        pin_lvl = 4'b0111; step();
        chk("R8", irq_out, 16'h0200);
        pin_lvl = 4'b0110; step();
        chk("R8", irq_out, 16'h0200);
        pin_lvl = 4'b0100; step();
        chk("R8", irq_out, 16'h0200);
        pin_lvl = 4'b1100; step();
        chk("R9", irq_out, 16'h0204);
        pin_lvl = 4'b0000; step();
        chk("R8", irq_out, 16'h0000);
    endtask

    task automatic t_storage();
        wr(8'h55, 8'h3B); wr(8'h56, 8'hD6); wr(8'h57, 8'hF8);
        rd_chk("R10", 8'h55, 8'h3B);
        rd_chk("R10", 8'h57, 8'hF8);
        pin_lvl = 4'b1111; step();
        chk("R10", irq_out, 16'h8000 | 16'h2000 | 16'h0040 | 16'h0008);
        chk("R10", irq_out, model(4'b1111));
        wr(8'h55, 8'h31); wr(8'h57, 8'hF4);
        step();
        chk("R10", irq_out, model(4'b1111));
        pin_lvl = '0; step();
    endtask

    task automatic t_latency_remap();
        wr(8'h55, 8'h50);
        step();
        pin_lvl = 4'b0001;
        #1;
        chk("R11", irq_out, 16'h0000);
        step();
        chk("R11", irq_out, 16'h0020);
        wr(8'h55, 8'h90);
        chk("R11", irq_out, 16'h0020);
        step();
        chk("R12", irq_out, 16'h0200);
        pin_lvl = '0;
        #1;
        chk("R11", irq_out, 16'h0200);
        step();
        chk("R11", irq_out, 16'h0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rw();
        t_outside();
        t_single("R4", 0, 4'd0);
        t_single("R4", 0, 4'd15);
        t_single("R5", 1, 4'd7);
        t_single("R5", 1, 4'd15);
        t_single("R6", 2, 4'd3);
        t_single("R6", 2, 4'd12);
        t_single("R7", 3, 4'd1);
        t_single("R7", 3, 4'd14);
        t_share();
        t_storage();
        t_latency_remap();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule